// File: doc/BRIEF.md
# Link-Layer Frame Receiver with CRC Freeze and Replay Recovery

This block sits behind the deserializer of a chip-to-chip serial memory link. Each cycle it may receive one 80-bit frame. It checks the frame's 6-bit CRC. If the frame is good and carries transaction data, the block hands the 72-bit payload to the target queue. For every good frame it accepts, it raises an acknowledge-generation pulse, which the local transmitter counts and returns to the peer. It also takes the peer's acknowledge bit from good frames and passes it on as a pulse for the local transmitter's acknowledge counter.

Recovery sends no negative acknowledgement. On the first CRC error the receiver freezes. It stops posting, stops acknowledging and ignores the peer's acknowledge bit. It stays frozen until a Replay link-control frame with a good CRC arrives. The peer sees the acknowledge count stop advancing and replays from its queue. The Replay frame itself is not acknowledged. All outputs are registered and follow the accepted frame by one cycle.

Top module: `lrx_top`

## Requirements
- R1: Frame fields: bits [79:8] are the payload, bit [7] is the link-control flag, bit [6] is the peer's acknowledge bit, and bits [5:0] hold the CRC. The CRC covers bits [79:6], most significant bit first, with the generator x^6+x+1 (0x03) and a seed of 6'h3F. A mismatch in any of the 80 bits makes the frame bad.
- R2: A good frame with the flag at 0, received while running, raises `post_valid` for exactly one cycle, one clock after the frame. `post_data` then equals the frame's payload.
- R3: Every good frame accepted while running produces exactly one `ack_pulse`, one clock later. This covers data frames and no-op link-control frames.
- R4: A frame with a bad CRC produces no post, no `ack_pulse` and no `peer_ack_pulse`. It puts the receiver into the frozen state.
- R5: While frozen, good data frames and good no-op link-control frames are discarded. They produce no post, no `ack_pulse` and no `peer_ack_pulse`.
- R6: A Replay frame has the flag at 1 and opcode payload[71:64] = 8'h02. A good Replay frame ends the frozen state. It is never posted or acknowledged, but its acknowledge bit is reported. Frames that follow it are handled normally.
- R7: A Replay frame with a bad CRC does not end the frozen state.
- R8: A link-control frame whose opcode is not 8'h02 (Pause uses 8'h01) is a no-op. While running it posts nothing but is acknowledged.
- R9: While running, a good frame with bit [6] at 1 produces one `peer_ack_pulse`, one clock later. If bit [6] is 0, no pulse is produced.
- R10: After reset all outputs are 0 and the receiver is running.
- R11: A cycle with `in_valid` low changes no output and no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A frame is present on `in_frame` |
| in_frame | input | 80 | Received frame |
| post_valid | output | 1 | Payload is written to the target queue this cycle |
| post_data | output | 72 | Payload being posted |
| ack_pulse | output | 1 | One acknowledge to be returned to the peer |
| peer_ack_pulse | output | 1 | The peer acknowledged one of the local frames |

## Verification
A freeze flag stuck at 0 shows up on the first good data frame after an error. That frame is posted and acknowledged when it should be discarded, visible one clock after it arrives. A flag stuck at 1 shows up as a Replay that fails to restart posting, seen on the data frame that follows it. A wrong CRC seed or polynomial rejects the very first good frame, so `post_valid` and `ack_pulse` stay low one cycle after it. Swapped flag or acknowledge bit positions appear at once as a wrong `peer_ack_pulse` or a no-op frame being posted.

// File: rtl/lrx_pkg.sv
package lrx_pkg;
  typedef enum logic {
    LRX_RUN  = 1'b0,
    LRX_HOLD = 1'b1
  } lrx_state_e;

  localparam int LRX_PAY_W  = 72;
  localparam int LRX_CRC_W  = 6;
  localparam int LRX_OP_W   = 8;
endpackage

// File: rtl/lrx_crc_chk.sv
module lrx_crc_chk #(
  parameter int              DATA_W = 74,
  parameter int              CRC_W  = 6,
  parameter logic [CRC_W-1:0] POLY  = 6'h03,
  parameter logic [CRC_W-1:0] SEED  = 6'h3F
) (
  input  logic [DATA_W-1:0] data,
  input  logic [CRC_W-1:0]  crc_rx,
  output logic              crc_ok
);
  logic [CRC_W-1:0] reg_c;
  logic             fb;

  // serial LFSR, MSB first, unrolled
  always_comb begin
    reg_c = SEED;
    fb    = 1'b0;
    for (int i = DATA_W - 1; i >= 0; i--) begin
      fb    = data[i] ^ reg_c[CRC_W-1];
      reg_c = {reg_c[CRC_W-2:0], 1'b0};
      if (fb) reg_c = reg_c ^ POLY;
    end
    crc_ok = (reg_c == crc_rx);
  end
endmodule

// File: rtl/lrx_classify.sv
module lrx_classify #(
  parameter int            OP_W      = 8,
  parameter logic [OP_W-1:0] OP_REPLAY = 8'h02
) (
  input  logic            ctl,
  input  logic [OP_W-1:0] opcode,
  output logic            is_data,
  output logic            is_replay
);
  assign is_data   = ~ctl;
  assign is_replay = ctl & (opcode == OP_REPLAY);
endmodule

// File: rtl/lrx_recover.sv
module lrx_recover
  import lrx_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic valid,
  input  logic crc_ok,
  input  logic is_data,
  input  logic is_replay,
  output logic do_post,
  output logic do_ack,
  output logic do_peer
);
  lrx_state_e state_q, state_d;
  logic good, running;

  assign good    = valid & crc_ok;
  assign running = (state_q == LRX_RUN);
  assign do_post = good & running & is_data;
  assign do_ack  = good & running & ~is_replay;
  assign do_peer = good & (running | is_replay);

  always_comb begin
    state_d = state_q;
    if (valid && !crc_ok)      state_d = LRX_HOLD;
    else if (good && is_replay) state_d = LRX_RUN;
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= LRX_RUN;
    else     state_q <= state_d;
  end

  assert_freeze_on_error_R4: assert property (@(posedge clk) disable iff (rst)
    (valid && !crc_ok) |=> (state_q == LRX_HOLD));

  assert_replay_resumes_R6: assert property (@(posedge clk) disable iff (rst)
    (state_q == LRX_HOLD && valid && crc_ok && is_replay) |=> (state_q == LRX_RUN));

  assert_stay_frozen_R7: assert property (@(posedge clk) disable iff (rst)
    (state_q == LRX_HOLD && !(valid && crc_ok && is_replay)) |=> (state_q == LRX_HOLD));

  assert_idle_holds_state_R11: assert property (@(posedge clk) disable iff (rst)
    !valid |=> $stable(state_q));
endmodule

// File: rtl/lrx_top.sv
module lrx_top #(
  parameter int PAY_W = lrx_pkg::LRX_PAY_W,
  parameter int CRC_W = lrx_pkg::LRX_CRC_W,
  parameter int OP_W  = lrx_pkg::LRX_OP_W,
  parameter logic [CRC_W-1:0] CRC_POLY  = 6'h03,
  parameter logic [CRC_W-1:0] CRC_SEED  = 6'h3F,
  parameter logic [OP_W-1:0]  OP_REPLAY = 8'h02,
  localparam int FRAME_W = PAY_W + 2 + CRC_W,
  localparam int CHK_W   = PAY_W + 2,
  localparam int CTL_BIT = CRC_W + 1,
  localparam int ACK_BIT = CRC_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic [FRAME_W-1:0] in_frame,
  output logic               post_valid,
  output logic [PAY_W-1:0]   post_data,
  output logic               ack_pulse,
  output logic               peer_ack_pulse
);
  logic crc_ok, is_data, is_replay;
  logic do_post, do_ack, do_peer;

  lrx_crc_chk #(.DATA_W(CHK_W), .CRC_W(CRC_W), .POLY(CRC_POLY), .SEED(CRC_SEED)) u_crc (
    .data   (in_frame[FRAME_W-1:CRC_W]),
    .crc_rx (in_frame[CRC_W-1:0]),
    .crc_ok (crc_ok)
  );

  lrx_classify #(.OP_W(OP_W), .OP_REPLAY(OP_REPLAY)) u_cls (
    .ctl       (in_frame[CTL_BIT]),
    .opcode    (in_frame[FRAME_W-1 -: OP_W]),
    .is_data   (is_data),
    .is_replay (is_replay)
  );

  lrx_recover u_rec (
    .clk       (clk),
    .rst       (rst),
    .valid     (in_valid),
    .crc_ok    (crc_ok),
    .is_data   (is_data),
    .is_replay (is_replay),
    .do_post   (do_post),
    .do_ack    (do_ack),
    .do_peer   (do_peer)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      post_valid     <= 1'b0;
      post_data      <= '0;
      ack_pulse      <= 1'b0;
      peer_ack_pulse <= 1'b0;
    end else begin
      post_valid     <= do_post;
      ack_pulse      <= do_ack;
      peer_ack_pulse <= do_peer & in_frame[ACK_BIT];
      if (do_post) post_data <= in_frame[FRAME_W-1:FRAME_W-PAY_W];
    end
  end

  assert_post_is_acked_R3: assert property (@(posedge clk) disable iff (rst)
    post_valid |-> ack_pulse);

  assert_bad_crc_silent_R4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !crc_ok) |=> (!post_valid && !ack_pulse && !peer_ack_pulse));

  assert_post_needs_frame_R11: assert property (@(posedge clk) disable iff (rst)
    post_valid |-> $past(in_valid));

  assert_replay_not_acked_R6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && is_replay) |=> (!ack_pulse && !post_valid));
endmodule

// File: tb/lrx_top_test.sv
module lrx_top_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [79:0] in_frame = '0;
  logic        post_valid;
  logic [71:0] post_data;
  logic        ack_pulse;
  logic        peer_ack_pulse;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  lrx_top uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_frame(in_frame),
    .post_valid(post_valid), .post_data(post_data),
    .ack_pulse(ack_pulse), .peer_ack_pulse(peer_ack_pulse)
  );

  function automatic logic [5:0] ref_crc(input logic [73:0] d);
    logic [5:0] c = 6'h3F;
    for (int i = 73; i >= 0; i--) begin
      logic f = d[i] ^ c[5];
      c = {c[4:0], 1'b0} ^ (f ? 6'h03 : 6'h00);
    end
    return c;
  endfunction

  function automatic logic [79:0] mk(input logic [71:0] pay, input logic ctl,
                                     input logic ack, input int flip);
    logic [79:0] f;
    f = {pay, ctl, ack, ref_crc({pay, ctl, ack})};
    if (flip >= 0) f[flip] = ~f[flip];
    return f;
  endfunction

  function automatic logic [71:0] op(input logic [7:0] code);
    return {code, 64'h0};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [71:0] act,
                     input logic [71:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive one frame at negedge, sample its result at the next negedge
  task automatic send(input logic [79:0] f);
    @(negedge clk);
    in_valid = 1'b1;
    in_frame = f;
    @(negedge clk);
    in_valid = 1'b0;
    in_frame = '0;
  endtask

  task automatic expect_out(input string req, input bit p, input logic [71:0] d,
                            input bit a, input bit pa);
    chk(post_valid == p, req, {71'h0, post_valid}, {71'h0, p});
    if (p) chk(post_data == d, req, post_data, d);
    chk(ack_pulse == a, req, {71'h0, ack_pulse}, {71'h0, a});
    chk(peer_ack_pulse == pa, req, {71'h0, peer_ack_pulse}, {71'h0, pa});
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    expect_out("R10 reset", 1'b0, '0, 1'b0, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    expect_out("R10 after reset", 1'b0, '0, 1'b0, 1'b0);
  endtask

  task automatic t_data;
    logic [71:0] p1 = 72'h12_3456_789A_BCDE_F012;
    logic [71:0] p2 = 72'hFF_0000_FFFF_0000_AAAA;
    send(mk(p1, 1'b0, 1'b0, -1));
    expect_out("R2 R3 R1 data no peer ack", 1'b1, p1, 1'b1, 1'b0);
    send(mk(p2, 1'b0, 1'b1, -1));
    expect_out("R2 R9 data with peer ack", 1'b1, p2, 1'b1, 1'b1);
  endtask

  task automatic t_idle;
    @(negedge clk);
    in_frame = mk(72'h5, 1'b0, 1'b1, -1);
    @(negedge clk);
    expect_out("R11 idle", 1'b0, '0, 1'b0, 1'b0);
    in_frame = '0;
  endtask

  task automatic t_pause;
    send(mk(op(8'h01), 1'b1, 1'b1, -1));
    expect_out("R8 pause", 1'b0, '0, 1'b1, 1'b1);
    send(mk(op(8'h33), 1'b1, 1'b0, -1));
    expect_out("R8 other ctl no-op", 1'b0, '0, 1'b1, 1'b0);
  endtask

  task automatic t_back_to_back;
    logic [71:0] a = 72'hA1_A2A3_A4A5_A6A7_A8A9;
    logic [71:0] b = 72'hB1_B2B3_B4B5_B6B7_B8B9;
    @(negedge clk);
    in_valid = 1'b1; in_frame = mk(a, 1'b0, 1'b0, -1);
    @(negedge clk);
    expect_out("R2 stream first", 1'b1, a, 1'b1, 1'b0);
    in_frame = mk(b, 1'b0, 1'b1, -1);
    @(negedge clk);
    in_valid = 1'b0; in_frame = '0;
    expect_out("R2 stream second", 1'b1, b, 1'b1, 1'b1);
  endtask

  task automatic t_replay_running;
    send(mk(op(8'h02), 1'b1, 1'b1, -1));
    expect_out("R6 replay while running", 1'b0, '0, 1'b0, 1'b1);
    send(mk(72'h77, 1'b0, 1'b0, -1));
    expect_out("R6 data after running replay", 1'b1, 72'h77, 1'b1, 1'b0);
  endtask

  task automatic t_freeze(input int flip);
    send(mk(72'hDEAD, 1'b0, 1'b1, flip));
    expect_out("R4 R1 bad crc frame", 1'b0, '0, 1'b0, 1'b0);
    send(mk(72'h1111, 1'b0, 1'b1, -1));
    expect_out("R5 good data while frozen", 1'b0, '0, 1'b0, 1'b0);
    send(mk(op(8'h01), 1'b1, 1'b1, -1));
    expect_out("R5 pause while frozen", 1'b0, '0, 1'b0, 1'b0);
    send(mk(op(8'h02), 1'b1, 1'b1, 3));
    expect_out("R7 bad replay", 1'b0, '0, 1'b0, 1'b0);
    send(mk(72'h2222, 1'b0, 1'b0, -1));
    expect_out("R7 still frozen after bad replay", 1'b0, '0, 1'b0, 1'b0);
    send(mk(op(8'h02), 1'b1, 1'b1, -1));
    expect_out("R6 good replay", 1'b0, '0, 1'b0, 1'b1);
    send(mk(72'h3333, 1'b0, 1'b1, -1));
    expect_out("R6 resumed data", 1'b1, 72'h3333, 1'b1, 1'b1);
  endtask

  initial begin
    t_reset();
    t_data();
    t_idle();
    t_pause();
    t_back_to_back();
    t_replay_running();
    t_freeze(79);
    t_freeze(7);
    t_freeze(0);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule